// File: doc/BRIEF.md
# Serial Flash Status Register and Busy Arbiter

This block keeps the ready/busy flag and the compare-result flag of a serial page flash. It also decides whether a newly decoded command may begin while a self-timed array operation is running. Commands arrive as a decoded class code with a one-cycle valid strobe. Each command is answered one cycle later by either a grant pulse or a reject pulse. A rejected command changes nothing inside the block.

The self-timed engines report to the block with a start pulse that carries the operation class, and with a done pulse that carries a mismatch flag. The block drives an active-low ready/busy output for an external open-drain pin. After a status-read grant, it streams the 8-bit status byte MSB first, one bit per bit-clock enable, for as long as chip select stays low. The byte repeats without limit. The ready bit is always live. The lower seven bits are captured again at the start of each repeat.

Top module: `flash_status_arb`

## Requirements
- R1: After reset, rdy_busy_n is 1, so_oe is 0, cmd_grant and cmd_reject are 0, and the compare flag is 0.
- R2: eng_start with a timed class (4 to 11) while ready makes rdy_busy_n 0 from the next cycle. eng_done while busy makes it 1 again. eng_start with class 0 to 3, or any eng_start while busy, is ignored.
- R3: When an operation of class 5 (compare) finishes, the compare flag takes the value of eng_mismatch. The done of any other operation leaves the flag unchanged.
- R4: Status byte layout: bit 7 is ready (1 = ready), bit 6 is the compare flag (1 = differs), bits 5 to 2 are the density code 0011, and bits 1 and 0 are 0.
- R5: A granted status read (class 0) sets so_oe and presents bit 7 in the cycle after the grant. Each cycle with bit_en moves to the next lower bit, and bit 0 is followed by bit 7. cs_n high ends the stream, and so_oe and so_bit then read 0.
- R6: While bit 7 is presented, so_bit follows the live ready state even if bit_en is held low. Bits 6 to 0 come from a copy taken on leaving bit 7, so a change made during a byte shows up only in the next repeat.
- R7: While busy, array-class commands (classes 3 to 11) are rejected.
- R8: A status read (class 0) is always granted.
- R9: Buffer read (1) and buffer write (2) are granted while ready or while the busy operation is a page erase (8) or a block erase (9). They are rejected during any other busy operation.
- R10: A reject is a single-cycle pulse and never appears together with a grant. It leaves the busy state, the stream and the compare flag unchanged.
- R11: Class codes 12 to 15 are always rejected.
- R12: rst_n low aborts a busy operation and a running stream at once, and the block stays idle until rst_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; aborts and holds the block idle |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_class | input | 4 | Decoded command class |
| cs_n | input | 1 | Chip select, active low |
| bit_en | input | 1 | Serial bit clock enable |
| eng_start | input | 1 | Engine start pulse |
| eng_op | input | 4 | Class of the operation being started |
| eng_done | input | 1 | Engine completion pulse |
| eng_mismatch | input | 1 | Compare result valid with eng_done |
| cmd_grant | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command refused pulse |
| rdy_busy_n | output | 1 | Ready/busy, low while busy |
| so_bit | output | 1 | Serial status bit |
| so_oe | output | 1 | Serial output enable |

## Verification
The hardest case to reach is a status change that lands in the middle of a byte being shifted out. The snapshot must hide the change until the next repeat, while the ready bit must show it at once. The bench reaches this case by starting a compare, granting a status read, and stepping exactly one bit past bit 7 before it pulses done with a mismatch. It also parks the stream on bit 7 with bit_en held low and finishes a transfer there, to check that the live ready bit follows. The group rule is walked from a vector table that sets up each busy operation and then offers a command.

// File: rtl/fsa_pkg.sv
`timescale 1ns/1ps
package fsa_pkg;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CMD_STATUS    = 4'd0,
        CMD_BUF_RD    = 4'd1,
        CMD_BUF_WR    = 4'd2,
        CMD_ARR_RD    = 4'd3,
        CMD_XFER      = 4'd4,
        CMD_CMP       = 4'd5,
        CMD_PROG_ER   = 4'd6,
        CMD_PROG_NE   = 4'd7,
        CMD_PG_ERASE  = 4'd8,
        CMD_BLK_ERASE = 4'd9,
        CMD_PROG_BUF  = 4'd10,
        CMD_REWRITE   = 4'd11
    } cmd_e;

    // class uses the array (read or self-timed)
    function automatic logic is_array(input logic [CLS_W-1:0] c);
        return (c >= CMD_ARR_RD) && (c <= CMD_REWRITE);
    endfunction

    // class runs a self-timed operation that sets busy
    function automatic logic is_timed(input logic [CLS_W-1:0] c);
        return (c >= CMD_XFER) && (c <= CMD_REWRITE);
    endfunction

    function automatic logic is_erase(input logic [CLS_W-1:0] c);
        return (c == CMD_PG_ERASE) || (c == CMD_BLK_ERASE);
    endfunction

    function automatic logic is_buffer(input logic [CLS_W-1:0] c);
        return (c == CMD_BUF_RD) || (c == CMD_BUF_WR);
    endfunction
endpackage

// File: rtl/fsa_busy.sv
`timescale 1ns/1ps
module fsa_busy
    import fsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_start,
    input  logic [CLS_W-1:0] eng_op,
    input  logic             eng_done,
    input  logic             eng_mismatch,
    output logic             busy,
    output logic [CLS_W-1:0] cur_op,
    output logic             cmp_flag
);
    typedef struct packed {
        logic             busy;
        logic [CLS_W-1:0] op;
        logic             cmp;
    } busy_st_t;

    busy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (eng_done) begin
                st_d.busy = 1'b0;
                if (st_q.op == CMD_CMP) begin
                    st_d.cmp = eng_mismatch;
                end
            end
        end else if (eng_start && is_timed(eng_op)) begin
            st_d.busy = 1'b1;
            st_d.op   = eng_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign cur_op   = st_q.op;
    assign cmp_flag = st_q.cmp;
endmodule

// File: rtl/fsa_gate.sv
`timescale 1ns/1ps
module fsa_gate
    import fsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CLS_W-1:0] cmd_class,
    input  logic             busy,
    input  logic [CLS_W-1:0] cur_op,
    output logic             status_go,
    output logic             grant,
    output logic             reject
);
    typedef struct packed {
        logic grant;
        logic reject;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     ok;

    always_comb begin
        if (cmd_class == CMD_STATUS) begin
            ok = 1'b1;
        end else if (is_buffer(cmd_class)) begin
            ok = !busy || is_erase(cur_op);
        end else if (is_array(cmd_class)) begin
            ok = !busy;
        end else begin
            ok = 1'b0;
        end
        st_d.grant  = cmd_valid && ok;
        st_d.reject = cmd_valid && !ok;
    end

    assign status_go = cmd_valid && (cmd_class == CMD_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant  = st_q.grant;
    assign reject = st_q.reject;
endmodule

// File: rtl/fsa_shift.sv
`timescale 1ns/1ps
module fsa_shift #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cs_n,
    input  logic              bit_en,
    input  logic [STAT_W-1:0] live,
    output logic              so_bit,
    output logic              so_oe
);
    localparam int IDX_W = $clog2(STAT_W);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(STAT_W - 1);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [STAT_W-1:0] shadow;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = TOP;
        end else if (st_q.active) begin
            if (cs_n) begin
                st_d.active = 1'b0;
                st_d.idx    = TOP;
            end else if (bit_en) begin
                if (st_q.idx == TOP) begin
                    st_d.shadow = live;
                end
                st_d.idx = (st_q.idx == '0) ? TOP : st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_oe  = st_q.active;
    assign so_bit = st_q.active &&
                    ((st_q.idx == TOP) ? live[STAT_W-1] : st_q.shadow[st_q.idx]);
endmodule

// File: rtl/flash_status_arb.sv
`timescale 1ns/1ps
module flash_status_arb
    import fsa_pkg::*;
#(
    parameter int          STAT_W  = 8,
    parameter int          DEN_W   = 4,
    parameter logic [3:0]  DEN_VAL = 4'b0011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_class,
    input  logic       cs_n,
    input  logic       bit_en,
    input  logic       eng_start,
    input  logic [3:0] eng_op,
    input  logic       eng_done,
    input  logic       eng_mismatch,
    output logic       cmd_grant,
    output logic       cmd_reject,
    output logic       rdy_busy_n,
    output logic       so_bit,
    output logic       so_oe
);
    localparam int PAD_W = STAT_W - 2 - DEN_W;

    logic             busy;
    logic [CLS_W-1:0] cur_op;
    logic             cmp_flag;
    logic             status_go;
    logic [STAT_W-1:0] live;

    fsa_busy u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_start    (eng_start),
        .eng_op       (eng_op),
        .eng_done     (eng_done),
        .eng_mismatch (eng_mismatch),
        .busy         (busy),
        .cur_op       (cur_op),
        .cmp_flag     (cmp_flag)
    );

    fsa_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .busy      (busy),
        .cur_op    (cur_op),
        .status_go (status_go),
        .grant     (cmd_grant),
        .reject    (cmd_reject)
    );

    assign live = {~busy, cmp_flag, DEN_VAL[DEN_W-1:0], {PAD_W{1'b0}}};

    fsa_shift #(.STAT_W(STAT_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (status_go),
        .cs_n   (cs_n),
        .bit_en (bit_en),
        .live   (live),
        .so_bit (so_bit),
        .so_oe  (so_oe)
    );

    assign rdy_busy_n = ~busy;
endmodule

// File: rtl/fsa_chk.sv
`timescale 1ns/1ps
module fsa_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_class,
    input logic       cs_n,
    input logic       bit_en,
    input logic       eng_start,
    input logic [3:0] eng_op,
    input logic       eng_done,
    input logic       eng_mismatch,
    input logic       cmd_grant,
    input logic       cmd_reject,
    input logic       rdy_busy_n,
    input logic       so_bit,
    input logic       so_oe
);
    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && rdy_busy_n && eng_op >= 4'd4 && eng_op <= 4'd11) |=> !rdy_busy_n);

    // R2
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !rdy_busy_n) |=> rdy_busy_n);

    // R7
    arr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rdy_busy_n && cmd_class >= 4'd3 && cmd_class <= 4'd11) |=> cmd_reject);

    // R8
    status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class == 4'd0) |=> (cmd_grant && so_oe));

    // R10
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_grant, cmd_reject}));

    // R10
    idle_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(cmd_grant || cmd_reject));

    // R11
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class >= 4'd12) |=> cmd_reject);

    // R5
    cs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && cs_n && !cmd_valid) |=> (!so_oe && !so_bit));

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so_bit);

    // R2
    stray_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_busy_n && !(eng_start && eng_op >= 4'd4 && eng_op <= 4'd11)) |=> rdy_busy_n);

    logic unused_ok;
    assign unused_ok = bit_en ^ eng_mismatch;
endmodule

bind flash_status_arb fsa_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_class    (cmd_class),
    .cs_n         (cs_n),
    .bit_en       (bit_en),
    .eng_start    (eng_start),
    .eng_op       (eng_op),
    .eng_done     (eng_done),
    .eng_mismatch (eng_mismatch),
    .cmd_grant    (cmd_grant),
    .cmd_reject   (cmd_reject),
    .rdy_busy_n   (rdy_busy_n),
    .so_bit       (so_bit),
    .so_oe        (so_oe)
);

// File: tb/sim_flash_status_arb.sv
`timescale 1ns/1ps
module sim_flash_status_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_class = 4'd0;
    logic       cs_n = 1'b1;
    logic       bit_en = 1'b0;
    logic       eng_start = 1'b0;
    logic [3:0] eng_op = 4'd0;
    logic       eng_done = 1'b0;
    logic       eng_mismatch = 1'b0;
    logic       cmd_grant, cmd_reject, rdy_busy_n, so_bit, so_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    flash_status_arb u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
        .cs_n(cs_n), .bit_en(bit_en), .eng_start(eng_start), .eng_op(eng_op),
        .eng_done(eng_done), .eng_mismatch(eng_mismatch), .cmd_grant(cmd_grant),
        .cmd_reject(cmd_reject), .rdy_busy_n(rdy_busy_n), .so_bit(so_bit), .so_oe(so_oe)
    );

    // {busy, op[3:0], cls[3:0], expect_grant}
    localparam int NV = 19;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 4'd0, 4'd0,  1'b1},
        {1'b0, 4'd0, 4'd1,  1'b1},
        {1'b0, 4'd0, 4'd2,  1'b1},
        {1'b0, 4'd0, 4'd3,  1'b1},
        {1'b0, 4'd0, 4'd5,  1'b1},
        {1'b0, 4'd0, 4'd11, 1'b1},
        {1'b0, 4'd0, 4'd12, 1'b0},
        {1'b0, 4'd0, 4'd15, 1'b0},
        {1'b1, 4'd4, 4'd0,  1'b1},
        {1'b1, 4'd4, 4'd1,  1'b0},
        {1'b1, 4'd4, 4'd2,  1'b0},
        {1'b1, 4'd4, 4'd3,  1'b0},
        {1'b1, 4'd4, 4'd6,  1'b0},
        {1'b1, 4'd8, 4'd1,  1'b1},
        {1'b1, 4'd8, 4'd2,  1'b1},
        {1'b1, 4'd8, 4'd10, 1'b0},
        {1'b1, 4'd9, 4'd2,  1'b1},
        {1'b1, 4'd9, 4'd4,  1'b0},
        {1'b1, 4'd9, 4'd13, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_op(input logic [3:0] op);
        eng_start = 1'b1; eng_op = op;
        tick();
        eng_start = 1'b0;
    endtask

    task automatic finish_op(input logic mm);
        eng_done = 1'b1; eng_mismatch = mm;
        tick();
        eng_done = 1'b0; eng_mismatch = 1'b0;
    endtask

    task automatic issue(input logic [3:0] cls);
        cmd_valid = 1'b1; cmd_class = cls;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic step_bit();
        bit_en = 1'b1;
        tick();
        bit_en = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            b[i] = so_bit;
            step_bit();
        end
    endtask

    function automatic string vec_tag(input logic busy, input logic [3:0] op, input logic [3:0] cls);
        if (cls >= 4'd12) return "R11";
        if (cls == 4'd0) return "R8";
        if (cls == 4'd1 || cls == 4'd2) return "R9";
        if (busy) return "R7";
        return "R7 idle";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rdy", rdy_busy_n, 1);
        chk("R1 oe", so_oe, 0);
        chk("R1 grant", cmd_grant, 0);
        chk("R1 reject", cmd_reject, 0);

        // R4 R5 R1: idle byte 8C, compare flag 0
        cs_n = 1'b0;
        issue(4'd0);
        chk("R5 oe", so_oe, 1);
        read_byte(b);
        chk("R4 byte", b, 8'h8C);
        read_byte(b);
        chk("R5 repeat", b, 8'h8C);
        cs_n = 1'b1;
        tick();
        chk("R5 cs end oe", so_oe, 0);
        chk("R5 cs end bit", so_bit, 0);
        cs_n = 1'b0;

        // vector walk of group rule
        for (int i = 0; i < NV; i++) begin
            logic vb; logic [3:0] vo; logic [3:0] vc; logic ve;
            {vb, vo, vc, ve} = VEC[i];
            if (vb) start_op(vo);
            issue(vc);
            chk(vec_tag(vb, vo, vc), {cmd_grant, cmd_reject}, {ve, ~ve});
            tick();
            chk("R10 pulse", {cmd_grant, cmd_reject}, 2'b00);
            if (vb) finish_op(1'b0);
            cs_n = 1'b1; tick(); cs_n = 1'b0;
        end

        // R2 non-timed start ignored
        start_op(4'd1);
        tick();
        chk("R2 ignore", rdy_busy_n, 1);
        // R2 start while busy ignored: op stays transfer
        start_op(4'd4);
        chk("R2 busy", rdy_busy_n, 0);
        start_op(4'd8);
        issue(4'd1);
        chk("R2 op kept", cmd_reject, 1);
        finish_op(1'b0);
        chk("R2 done", rdy_busy_n, 1);

        // R3 compare mismatch
        start_op(4'd5);
        finish_op(1'b1);
        issue(4'd0);
        read_byte(b);
        chk("R3 set", b, 8'hCC);
        start_op(4'd8);
        finish_op(1'b0);
        read_byte(b);
        chk("R3 kept", b, 8'hCC);
        start_op(4'd5);
        finish_op(1'b0);
        read_byte(b);
        chk("R3 clear", b, 8'h8C);

        // R6 snapshot mid byte
        start_op(4'd5);
        issue(4'd0);
        chk("R6 bit7 busy", so_bit, 0);
        step_bit();
        finish_op(1'b1);
        chk("R6 bit6 old", so_bit, 0);
        b = 8'h00;
        for (int i = 5; i >= 0; i--) begin
            step_bit();
            b[i] = so_bit;
        end
        chk("R6 low bits", b[5:0], 6'b001100);
        step_bit();
        chk("R6 live ready", so_bit, 1);
        read_byte(b);
        chk("R6 refresh", b, 8'hCC);

        // R6 poll bit 7 with clock stopped
        start_op(4'd4);
        issue(4'd0);
        tick(); tick();
        chk("R6 poll busy", so_bit, 0);
        finish_op(1'b0);
        chk("R6 poll ready", so_bit, 1);

        // R10 reject has no effect
        start_op(4'd4);
        step_bit();
        chk("R10 pre", so_bit, 1);
        issue(4'd6);
        chk("R10 reject", cmd_reject, 1);
        chk("R10 bit", so_bit, 1);
        tick();
        chk("R10 single", cmd_reject, 0);
        chk("R10 busy", rdy_busy_n, 0);
        chk("R10 oe", so_oe, 1);

        // R12 reset aborts
        rst_n = 1'b0;
        tick();
        chk("R12 rdy", rdy_busy_n, 1);
        chk("R12 oe", so_oe, 0);
        issue(4'd0);
        chk("R12 held", {cmd_grant, so_oe}, 2'b00);
        rst_n = 1'b1;
        tick();
        chk("R12 idle", {rdy_busy_n, so_oe}, 2'b10);
        issue(4'd0);
        read_byte(b);
        chk("R12 cmp cleared", b, 8'h8C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule